// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block is a first-in first-out buffer whose write side and read side run on separate, unrelated clocks. It holds up to 1024 words of 36 bits by default. A word is stored on a rising write-clock edge only when both write enables are high. A word is removed on a rising read-clock edge only when both read enables are high. The removed word appears on the registered read-data output after that edge.

Five active-low flags report how full the buffer is: empty, almost-empty, half-full, almost-full and full. The two "almost" thresholds are held in offset registers that can be rewritten at run time. A small control register selects whether the half-full and almost-full flags are decoded directly or registered on a chosen clock. Each side learns the other side's pointer through a multi-stage synchronizer carrying Gray code.

Configuration is written on the write clock through a select/data/strobe port. The almost-empty offset is used on the read side. It should therefore be changed only while the read side is quiet.

Top module: `dc_flag_fifo`

## Requirements
- R1: A write happens at a rising `wr_clk` edge only when `wr_en_a` and `wr_en_b` are both high, and a read happens at a rising `rd_clk` edge only when `rd_en_a` and `rd_en_b` are both high. Words leave in the order they entered, and the read word is on `rd_data` after the read edge.
- R2: `empty_n` is low when the read side sees no stored words. A read attempted while empty is ignored and does not move the read position.
- R3: `full_n` is low when 1024 words are stored. A write attempted while full is ignored and does not move the write position or overwrite stored data.
- R4: `afull_n` is low when the number of vacant locations is at most the almost-full offset. In the direct mode (control bit 5 = 0), it changes in the same write-clock cycle as the write that crosses the threshold.
- R5: `aempty_n` is low when the number of stored words is at most the almost-empty offset.
- R6: Both offsets reset to 8. A configuration write (`cfg_we` high at a `wr_clk` edge) stores `cfg_wdata` according to `cfg_sel`: 00 selects the almost-full offset, 01 the almost-empty offset, and 10 the control register. Code 11 writes nothing.
- R7: `hfull_n` is low when at least 513 words are stored. In the direct mode, it changes in the same write-clock cycle as the write that reaches 513.
- R8: Control bits 4:3 pick the half-full mode: 00 is a direct decode, 01 is registered on `rd_clk`, and 10 or 11 is registered on `wr_clk`. Control bit 5 = 1 registers almost-full on `wr_clk`. A registered flag follows the direct decode one cycle of its clock later.
- R9: After reset, `empty_n` and `aempty_n` are low, and `full_n`, `afull_n` and `hfull_n` are high. The control register resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_en_a | input | 1 | First write enable |
| wr_en_b | input | 1 | Second write enable |
| wr_data | input | 36 | Word to store |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| rd_data | output | 36 | Last word read, registered |
| cfg_we | input | 1 | Configuration write strobe (write clock) |
| cfg_sel | input | 2 | Configuration target select |
| cfg_wdata | input | 11 | Offset value or control bits |
| full_n | output | 1 | Full flag, active low |
| afull_n | output | 1 | Almost-full flag, active low |
| hfull_n | output | 1 | Half-full flag, active low |
| aempty_n | output | 1 | Almost-empty flag, active low |
| empty_n | output | 1 | Empty flag, active low |

## Verification
The bench fills the buffer word by word through every threshold. It samples each flag one word below and exactly at its boundary: 8 and 9 words for the default almost-empty offset, 512 and 513 for half-full, 1015 and 1016 for almost-full, and 1023 and 1024 for full. An off-by-one compare shows up as a flag that flips one word early or late. After filling, the bench writes while full and then drains everything. A design that let those writes through would wrap onto unread words and return corrupt data, or report data left over after the drain. The bench also reads while empty and then checks that the next real word comes out. It raises a single enable on each port to catch an OR where an AND belongs. Finally it samples the registered half-full and almost-full modes on the edge where they must still lag the direct decode, which exposes a mode bit that is decoded wrongly or a flag that is registered twice.

// File: rtl/dcff_pkg.sv
package dcff_pkg;
  typedef enum logic [1:0] {
    SEL_AF_OFF = 2'b00,
    SEL_AE_OFF = 2'b01,
    SEL_CTRL   = 2'b10,
    SEL_NONE   = 2'b11
  } cfg_sel_t;

  typedef enum logic [1:0] {
    HF_DIRECT  = 2'b00,
    HF_RDCLK   = 2'b01,
    HF_WRCLK   = 2'b10,
    HF_WRCLK_B = 2'b11
  } hf_mode_t;

  typedef struct packed {
    logic     af_wrclk;
    hf_mode_t hf_mode;
  } flag_ctrl_t;

  localparam int CTRL_HF_LSB = 3;
  localparam int CTRL_AF_BIT = 5;
endpackage

// File: rtl/dcff_gray_sync.sv
module dcff_gray_sync #(
  parameter int PW     = 11,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  logic [PW-1:0] pipe [STAGES];

  function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
    end else begin
      pipe[0] <= gray_in;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign bin_out = gray_to_bin(pipe[STAGES-1]);
endmodule

// File: rtl/dcff_wr_ctl.sv
module dcff_wr_ctl #(
  parameter int AW   = 10,
  parameter int SYNC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [AW:0] rgray_in,
  input  logic [AW:0] af_off,
  output logic [AW:0] wptr,
  output logic [AW:0] wgray,
  output logic        fire,
  output logic        full,
  output logic        afull,
  output logic        half
);
  localparam int          DEPTH   = 1 << AW;
  localparam int          HALF    = DEPTH / 2 + 1;
  localparam logic [AW:0] DEPTH_P = DEPTH[AW:0];
  localparam logic [AW:0] HALF_P  = HALF[AW:0];
  localparam logic [AW:0] ONE_P   = 1;

  logic [AW:0] rbin;
  logic [AW:0] count;
  logic [AW:0] wptr_nxt;

  function automatic logic [AW:0] occupancy(input logic [AW:0] head, input logic [AW:0] tail);
    return head - tail;
  endfunction

  function automatic logic [AW:0] vacancy(input logic [AW:0] used);
    return DEPTH_P - used;
  endfunction

  function automatic logic [AW:0] bin_to_gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  dcff_gray_sync #(.PW(AW + 1), .STAGES(SYNC)) u_rsync (
    .clk     (clk),
    .rst_n   (rst_n),
    .gray_in (rgray_in),
    .bin_out (rbin)
  );

  assign count    = occupancy(wptr, rbin);
  assign full     = (count == DEPTH_P);
  assign fire     = req & ~full;
  assign afull    = (vacancy(count) <= af_off);
  assign half     = (count >= HALF_P);
  assign wptr_nxt = fire ? wptr + ONE_P : wptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      wgray <= '0;
    end else begin
      wptr  <= wptr_nxt;
      wgray <= bin_to_gray(wptr_nxt);
    end
  end
endmodule

// File: rtl/dcff_rd_ctl.sv
module dcff_rd_ctl #(
  parameter int AW   = 10,
  parameter int SYNC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [AW:0] wgray_in,
  input  logic [AW:0] ae_off,
  output logic [AW:0] rptr,
  output logic [AW:0] rgray,
  output logic        fire,
  output logic        empty,
  output logic        aempty,
  output logic        half
);
  localparam int          DEPTH  = 1 << AW;
  localparam int          HALF   = DEPTH / 2 + 1;
  localparam logic [AW:0] HALF_P = HALF[AW:0];
  localparam logic [AW:0] ONE_P  = 1;

  logic [AW:0] wbin;
  logic [AW:0] count;
  logic [AW:0] rptr_nxt;

  function automatic logic [AW:0] occupancy(input logic [AW:0] head, input logic [AW:0] tail);
    return head - tail;
  endfunction

  function automatic logic [AW:0] bin_to_gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  dcff_gray_sync #(.PW(AW + 1), .STAGES(SYNC)) u_wsync (
    .clk     (clk),
    .rst_n   (rst_n),
    .gray_in (wgray_in),
    .bin_out (wbin)
  );

  assign count    = occupancy(wbin, rptr);
  assign empty    = (count == '0);
  assign fire     = req & ~empty;
  assign aempty   = (count <= ae_off);
  assign half     = (count >= HALF_P);
  assign rptr_nxt = fire ? rptr + ONE_P : rptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      rgray <= '0;
    end else begin
      rptr  <= rptr_nxt;
      rgray <= bin_to_gray(rptr_nxt);
    end
  end
endmodule

// File: rtl/dcff_mem.sv
module dcff_mem #(
  parameter int DW = 36,
  parameter int AW = 10
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/dc_flag_fifo.sv
module dc_flag_fifo
  import dcff_pkg::*;
#(
  parameter int DW          = 36,
  parameter int AW          = 10,
  parameter int SYNC_STAGES = 2,
  parameter int OFF_DEFAULT = 8
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          wr_en_a,
  input  logic          wr_en_b,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en_a,
  input  logic          rd_en_b,
  output logic [DW-1:0] rd_data,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW:0]   cfg_wdata,
  output logic          full_n,
  output logic          afull_n,
  output logic          hfull_n,
  output logic          aempty_n,
  output logic          empty_n
);
  localparam logic [AW:0] OFF_P = OFF_DEFAULT[AW:0];

  // Internal events, named for the checker
  logic        wr_req, rd_req, wr_fire, rd_fire;
  logic [AW:0] wptr, wgray, rptr, rgray;
  logic        full_w, afull_w, half_w;
  logic        empty_r, aempty_r, half_r;

  // Configuration (write clock)
  logic [AW:0] af_off, ae_off;
  flag_ctrl_t  ctrl;

  // Registered flag variants
  logic af_q, hfw_q, hfr_q, hf_sel, af_sel;

  assign wr_req = wr_en_a & wr_en_b;
  assign rd_req = rd_en_a & rd_en_b;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      af_off <= OFF_P;
      ae_off <= OFF_P;
      ctrl   <= '0;
    end else if (cfg_we) begin
      case (cfg_sel_t'(cfg_sel))
        SEL_AF_OFF: af_off <= cfg_wdata;
        SEL_AE_OFF: ae_off <= cfg_wdata;
        SEL_CTRL: begin
          ctrl.af_wrclk <= cfg_wdata[CTRL_AF_BIT];
          ctrl.hf_mode  <= hf_mode_t'(cfg_wdata[CTRL_HF_LSB+1:CTRL_HF_LSB]);
        end
        default: ;
      endcase
    end
  end

  dcff_wr_ctl #(.AW(AW), .SYNC(SYNC_STAGES)) u_wr (
    .clk      (wr_clk),
    .rst_n    (rst_n),
    .req      (wr_req),
    .rgray_in (rgray),
    .af_off   (af_off),
    .wptr     (wptr),
    .wgray    (wgray),
    .fire     (wr_fire),
    .full     (full_w),
    .afull    (afull_w),
    .half     (half_w)
  );

  dcff_rd_ctl #(.AW(AW), .SYNC(SYNC_STAGES)) u_rd (
    .clk      (rd_clk),
    .rst_n    (rst_n),
    .req      (rd_req),
    .wgray_in (wgray),
    .ae_off   (ae_off),
    .rptr     (rptr),
    .rgray    (rgray),
    .fire     (rd_fire),
    .empty    (empty_r),
    .aempty   (aempty_r),
    .half     (half_r)
  );

  dcff_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk  (wr_clk),
    .we    (wr_fire),
    .waddr (wptr[AW-1:0]),
    .wdata (wr_data),
    .rclk  (rd_clk),
    .rst_n (rst_n),
    .re    (rd_fire),
    .raddr (rptr[AW-1:0]),
    .rdata (rd_data)
  );

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      af_q  <= 1'b0;
      hfw_q <= 1'b0;
    end else begin
      af_q  <= afull_w;
      hfw_q <= half_w;
    end
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) hfr_q <= 1'b0;
    else        hfr_q <= half_r;
  end

  always_comb begin
    case (ctrl.hf_mode)
      HF_DIRECT: hf_sel = half_w;
      HF_RDCLK:  hf_sel = hfr_q;
      default:   hf_sel = hfw_q;
    endcase
    af_sel = ctrl.af_wrclk ? af_q : afull_w;
  end

  assign full_n   = ~full_w;
  assign afull_n  = ~af_sel;
  assign hfull_n  = ~hf_sel;
  assign aempty_n = ~aempty_r;
  assign empty_n  = ~empty_r;
endmodule

// File: rtl/dcff_chk.sv
module dcff_chk #(
  parameter int AW = 10
) (
  input logic        wr_clk,
  input logic        rd_clk,
  input logic        rst_n,
  input logic        wr_req,
  input logic        rd_req,
  input logic [AW:0] wptr,
  input logic [AW:0] rptr,
  input logic [AW:0] wgray,
  input logic        full_n,
  input logic        afull_n,
  input logic        hfull_n,
  input logic        aempty_n,
  input logic        empty_n,
  input logic        af_wrclk,
  input logic [1:0]  hf_mode
);
  assert_wr_gate_R1: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_req |=> $stable(wptr));

  assert_rd_gate_R1: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rd_req |=> $stable(rptr));

  // R1: the pointer handed across domains moves one bit at a time
  assert_gray_step_R1: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  assert_no_underflow_R2: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!empty_n && rd_req) |=> $stable(rptr));

  assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!full_n && wr_req) |=> $stable(wptr));

  assert_full_has_afull_R4: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!full_n && !af_wrclk) |-> !afull_n);

  assert_empty_has_aempty_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);

  assert_full_has_half_R7: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!full_n && hf_mode == 2'b00) |-> !hfull_n);
endmodule

bind dc_flag_fifo dcff_chk #(.AW(AW)) u_chk (
  .wr_clk   (wr_clk),
  .rd_clk   (rd_clk),
  .rst_n    (rst_n),
  .wr_req   (wr_req),
  .rd_req   (rd_req),
  .wptr     (wptr),
  .rptr     (rptr),
  .wgray    (wgray),
  .full_n   (full_n),
  .afull_n  (afull_n),
  .hfull_n  (hfull_n),
  .aempty_n (aempty_n),
  .empty_n  (empty_n),
  .af_wrclk (ctrl.af_wrclk),
  .hf_mode  (ctrl.hf_mode)
);

// File: tb/sim_dc_flag_fifo.sv
module sim_dc_flag_fifo;
  logic        wr_clk = 1'b0;
  logic        rd_clk = 1'b0;
  logic        rst_n;
  logic        wr_en_a, wr_en_b, rd_en_a, rd_en_b;
  logic [35:0] wr_data, rd_data;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [10:0] cfg_wdata;
  logic        full_n, afull_n, hfull_n, aempty_n, empty_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 wr_clk = ~wr_clk;
  initial begin
    #3;
    forever #5 rd_clk = ~rd_clk;
  end

  dc_flag_fifo u0 (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_en_a(wr_en_a), .wr_en_b(wr_en_b), .wr_data(wr_data),
    .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .rd_data(rd_data),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .full_n(full_n), .afull_n(afull_n), .hfull_n(hfull_n),
    .aempty_n(aempty_n), .empty_n(empty_n)
  );

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wr_en_a = 0; wr_en_b = 0; rd_en_a = 0; rd_en_b = 0;
    wr_data = '0; cfg_we = 0; cfg_sel = 2'b11; cfg_wdata = '0;
    repeat (3) @(negedge wr_clk);
    rst_n = 1'b1;
    repeat (2) @(negedge wr_clk);
  endtask

  task automatic settle();
    repeat (8) @(negedge wr_clk);
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [10:0] val);
    @(negedge wr_clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = val;
    @(negedge wr_clk);
    cfg_we = 0; cfg_sel = 2'b11;
  endtask

  task automatic push_burst(input int n, input logic [35:0] base);
    @(negedge wr_clk);
    wr_en_a = 1; wr_en_b = 1;
    for (int i = 0; i < n; i++) begin
      wr_data = base + 36'(i);
      @(negedge wr_clk);
    end
    wr_en_a = 0; wr_en_b = 0;
  endtask

  task automatic pop1(output logic [35:0] d);
    @(negedge rd_clk);
    rd_en_a = 1; rd_en_b = 1;
    @(negedge rd_clk);
    rd_en_a = 0; rd_en_b = 0;
    d = rd_data;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R9 empty_n after reset", 36'(empty_n), 36'd0);
    chk("R9 aempty_n after reset", 36'(aempty_n), 36'd0);
    chk("R9 full_n after reset", 36'(full_n), 36'd1);
    chk("R9 afull_n after reset", 36'(afull_n), 36'd1);
    chk("R9 hfull_n after reset", 36'(hfull_n), 36'd1);
  endtask

  task automatic t_enables();
    logic [35:0] d;
    do_reset();
    @(negedge wr_clk); wr_en_a = 1; wr_data = 36'h111;
    repeat (2) @(negedge wr_clk); wr_en_a = 0; wr_en_b = 1;
    repeat (2) @(negedge wr_clk); wr_en_b = 0;
    settle();
    chk("R1 single write enable stores nothing", 36'(empty_n), 36'd0);
    push_burst(1, 36'hA5A5A5A5A);
    push_burst(1, 36'h5A5A5A5A5);
    settle();
    chk("R1 both write enables store", 36'(empty_n), 36'd1);
    @(negedge rd_clk); rd_en_b = 1;
    repeat (2) @(negedge rd_clk); rd_en_b = 0;
    pop1(d);
    chk("R1 single read enable skipped, first word", d, 36'hA5A5A5A5A);
    pop1(d);
    chk("R1 order second word", d, 36'h5A5A5A5A5);
    settle();
    chk("R2 empty after draining", 36'(empty_n), 36'd0);
  endtask

  task automatic t_empty_reads();
    logic [35:0] d;
    pop1(d);
    pop1(d);
    push_burst(1, 36'hC0FFEE123);
    settle();
    pop1(d);
    chk("R2 read on empty ignored, next word intact", d, 36'hC0FFEE123);
    settle();
    chk("R2 empty again", 36'(empty_n), 36'd0);
  endtask

  task automatic t_fill_default();
    int errs;
    do_reset();
    push_burst(8, 36'd0);
    settle();
    chk("R6 R5 default ae offset, 8 words", 36'(aempty_n), 36'd0);
    push_burst(1, 36'd8);
    settle();
    chk("R6 R5 default ae offset, 9 words", 36'(aempty_n), 36'd1);
    push_burst(503, 36'd9);
    settle();
    chk("R7 512 words not half", 36'(hfull_n), 36'd1);
    @(negedge wr_clk); wr_en_a = 1; wr_en_b = 1; wr_data = 36'd512;
    @(negedge wr_clk); wr_en_a = 0; wr_en_b = 0;
    chk("R7 513th word sets half in same cycle", 36'(hfull_n), 36'd0);
    push_burst(502, 36'd513);
    settle();
    chk("R4 R6 vacancy 9 not almost full", 36'(afull_n), 36'd1);
    push_burst(1, 36'd1015);
    settle();
    chk("R4 R6 vacancy 8 almost full", 36'(afull_n), 36'd0);
    push_burst(7, 36'd1016);
    settle();
    chk("R3 1023 words not full", 36'(full_n), 36'd1);
    push_burst(1, 36'd1023);
    settle();
    chk("R3 1024 words full", 36'(full_n), 36'd0);
    push_burst(3, 36'hBADBADBAD);
    settle();
    errs = 0;
    @(negedge rd_clk); rd_en_a = 1; rd_en_b = 1;
    for (int i = 0; i < 1024; i++) begin
      @(negedge rd_clk);
      if (rd_data !== 36'(i)) errs++;
    end
    rd_en_a = 0; rd_en_b = 0;
    chk("R3 R1 drain order, writes while full dropped", 36'(errs), 36'd0);
    settle();
    chk("R3 empty after full drain", 36'(empty_n), 36'd0);
    chk("R3 full cleared after drain", 36'(full_n), 36'd1);
  endtask

  task automatic t_offsets_prog();
    do_reset();
    cfg(2'b01, 11'd20);
    cfg(2'b00, 11'd1000);
    cfg(2'b11, 11'd3);
    push_burst(20, 36'd0);
    settle();
    chk("R5 R6 ae offset 20 at 20 words", 36'(aempty_n), 36'd0);
    push_burst(1, 36'd20);
    settle();
    chk("R5 R6 ae offset 20 at 21 words", 36'(aempty_n), 36'd1);
    push_burst(2, 36'd21);
    settle();
    chk("R4 R6 af offset 1000 at 23 words", 36'(afull_n), 36'd1);
    @(negedge wr_clk); wr_en_a = 1; wr_en_b = 1; wr_data = 36'd23;
    @(negedge wr_clk); wr_en_a = 0; wr_en_b = 0;
    chk("R4 direct mode flags in same cycle at 24 words", 36'(afull_n), 36'd0);
    chk("R8 R9 select 11 left hf mode direct", 36'(hfull_n), 36'd1);
  endtask

  task automatic t_af_sync();
    do_reset();
    cfg(2'b00, 11'd1000);
    cfg(2'b10, 11'h020);
    push_burst(23, 36'd0);
    settle();
    chk("R8 registered af, 23 words", 36'(afull_n), 36'd1);
    @(negedge wr_clk); wr_en_a = 1; wr_en_b = 1; wr_data = 36'd23;
    @(negedge wr_clk); wr_en_a = 0; wr_en_b = 0;
    chk("R8 registered af lags on crossing edge", 36'(afull_n), 36'd1);
    @(negedge wr_clk);
    chk("R8 registered af set one cycle later", 36'(afull_n), 36'd0);
  endtask

  task automatic t_hf_modes();
    logic [35:0] d;
    do_reset();
    cfg(2'b10, 11'h010);
    push_burst(512, 36'd0);
    settle();
    chk("R8 wr-registered hf, 512 words", 36'(hfull_n), 36'd1);
    @(negedge wr_clk); wr_en_a = 1; wr_en_b = 1; wr_data = 36'd512;
    @(negedge wr_clk); wr_en_a = 0; wr_en_b = 0;
    chk("R8 wr-registered hf lags on crossing edge", 36'(hfull_n), 36'd1);
    @(negedge wr_clk);
    chk("R8 wr-registered hf set one cycle later", 36'(hfull_n), 36'd0);
    cfg(2'b10, 11'h008);
    settle();
    chk("R8 rd-registered hf at 513 words", 36'(hfull_n), 36'd0);
    pop1(d);
    chk("R8 rd-registered hf lags after read edge", 36'(hfull_n), 36'd0);
    @(negedge rd_clk);
    chk("R8 rd-registered hf cleared one rd cycle later", 36'(hfull_n), 36'd1);
    chk("R1 first word out in hf test", d, 36'd0);
  endtask

  initial begin
    t_reset_state();
    t_enables();
    t_empty_reads();
    t_fill_default();
    t_offsets_prog();
    t_af_sync();
    t_hf_modes();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule